// File: doc/BRIEF.md
# Bridge Error Capture and Signalling

This block gathers the error events raised on both sides of a bridge that connects a processor bus to a PCI bus. Each event arrives as a single-cycle pulse on one of seven source inputs. The block records it in a sticky status register and forwards it to the side where the faulty cycle ran. PCI-side problems go out on a system-error line or a parity-error line. Processor-bus problems go out as a pulse on one bit of a per-master error vector, and the index of the master that owned the failing cycle selects that bit.

Two separate sets of mask bits are held in the block. A detection mask bit for a source suppresses that source completely: nothing is recorded and nothing is signalled. A reporting mask bit for an output line only silences that line. The event is still captured in status, so software can find it by polling. Software reads the registers through a small register port. It clears captured errors by writing ones to the status register.

Top module: `bridge_err_report`

## Requirements
- R1: After reset the status register, the detection mask and the reporting mask all read zero, and serr_o, perr_o and merr_o are low.
- R2: The source bit order is: bit0 unsupported processor-bus transfer, bit1 master abort generated as PCI master, bit2 target abort received as PCI master, bit3 data parity as PCI target, bit4 data parity as PCI master, bit5 address parity as PCI target, bit6 processor-bus master error. A pulse on an undetection-masked source sets its status bit, which reads back at reg_addr 0 in bits 6:0 from the next cycle onward. The bit stays set until software clears it.
- R3: While detection mask bit n is 1 (reg_addr 1, bits 6:0), an event on source n sets no status bit and drives no output.
- R4: A write to reg_addr 0 clears each status bit whose wdata bit is 1 and leaves the others unchanged. If a new event on a source coincides with a clear of that source's bit, the bit ends up set.
- R5: A detected event on source 1, 2 or 5 pulses serr_o high for exactly the following cycle, unless reporting mask bit 0 is set.
- R6: A detected event on source 3 or 4 pulses perr_o high for exactly the following cycle, unless reporting mask bit 1 is set.
- R7: A detected event on source 0 or 6 raises merr_o bit err_mid for exactly the following cycle, unless reporting mask bit 2 is set. merr_o never has more than one bit high.
- R8: A reporting mask bit blocks only its own output. An event it silences is still captured in status.
- R9: reg_addr 1 holds the detection mask and reg_addr 2 holds the reporting mask (bits 2:0). Both are written with reg_wr. Unused register bits and reg_addr 3 read zero. A mask write applies from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_evt | input | 7 | Single-cycle error event pulses, one bit per source |
| err_mid | input | MID_W | Processor-bus master index of the failing cycle |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data for the selected register (combinational) |
| serr_o | output | 1 | System-error pulse |
| perr_o | output | 1 | Parity-error pulse |
| merr_o | output | NMST | Per-master processor-bus error pulse vector |

## Verification
Each piece of state in this block is visible at the ports within one cycle. A status bit that is lost, stuck, or cleared by the wrong write shows up on the next read of reg_addr 0 after the edge. A wrong mask bit or a wrong source-to-line routing shows up as a missing or extra pulse on serr_o, perr_o or merr_o in the cycle that follows the event. A decoding error in the master index lights the wrong merr_o bit in that same cycle.

// File: rtl/bridge_err_report.sv
module bridge_err_report #(
  parameter int NMST  = 16,
  parameter int MID_W = $clog2(NMST),
  parameter int DW    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [6:0]       err_evt,
  input  logic [MID_W-1:0] err_mid,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  output logic             serr_o,
  output logic             perr_o,
  output logic [NMST-1:0]  merr_o
);
  localparam int NSRC = 7;
  localparam logic [NSRC-1:0] SERR_SRC = 7'h26;
  localparam logic [NSRC-1:0] PERR_SRC = 7'h18;
  localparam logic [NSRC-1:0] MERR_SRC = 7'h41;
  localparam logic [NMST-1:0] ONE_M    = NMST'(1);

  logic [NSRC-1:0] status, det_mask, hit, clr;
  logic [2:0]      rep_mask;

  assign hit = err_evt & ~det_mask;
  assign clr = (reg_wr && reg_addr == 2'd0) ? reg_wdata[NSRC-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status   <= '0;
      det_mask <= '0;
      rep_mask <= '0;
      serr_o   <= 1'b0;
      perr_o   <= 1'b0;
      merr_o   <= '0;
    end else begin
      status <= (status & ~clr) | hit;
      if (reg_wr && reg_addr == 2'd1) det_mask <= reg_wdata[NSRC-1:0];
      if (reg_wr && reg_addr == 2'd2) rep_mask <= reg_wdata[2:0];
      serr_o <= |(hit & SERR_SRC) && !rep_mask[0];
      perr_o <= |(hit & PERR_SRC) && !rep_mask[1];
      merr_o <= (|(hit & MERR_SRC) && !rep_mask[2]) ? (ONE_M << err_mid) : '0;
    end
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = DW'(status);
      2'd1:    reg_rdata = DW'(det_mask);
      2'd2:    reg_rdata = DW'(rep_mask);
      default: reg_rdata = '0;
    endcase
  end

  // R2
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == 2'd0) |=> ((status & $past(status)) == $past(status)));

  // R3
  masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & $past(err_evt & det_mask & ~status)) == '0));

  // R5
  serr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    serr_o |-> ($past(|(err_evt & ~det_mask & SERR_SRC)) && !$past(rep_mask[0])));

  // R6
  perr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    perr_o |-> $past(|(err_evt & ~det_mask & PERR_SRC)));

  // R7
  merr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(merr_o));
endmodule

// File: tb/sim_bridge_err_report.sv
module sim_bridge_err_report;
  localparam int NMST = 16, MID_W = 4, DW = 16;
  logic clk = 0, rst_n = 0;
  logic [6:0] err_evt = '0;
  logic [MID_W-1:0] err_mid = '0;
  logic reg_wr = 0;
  logic [1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic serr_o, perr_o;
  logic [NMST-1:0] merr_o;

  int vectors = 0, errors = 0, cyc = 0;
  logic [6:0] m_stat = '0, m_det = '0;
  logic [2:0] m_rep = '0;
  logic e_serr, e_perr;
  logic [NMST-1:0] e_merr;

  always #2 clk = ~clk;

  bridge_err_report #(.NMST(NMST), .MID_W(MID_W), .DW(DW)) u0 (.*);

  function automatic logic [DW-1:0] model_read(input logic [1:0] a);
    case (a)
      2'd0: return DW'(m_stat);
      2'd1: return DW'(m_det);
      2'd2: return DW'(m_rep);
      default: return '0;
    endcase
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic [6:0] ev, input logic [MID_W-1:0] id, input logic wr,
                      input logic [1:0] a, input logic [DW-1:0] wd, input string rtag);
    logic [6:0] h;
    @(negedge clk);
    err_evt = ev; err_mid = id; reg_wr = wr; reg_addr = a; reg_wdata = wd;
    h = ev & ~m_det;
    e_serr = |(h & 7'h26) && !m_rep[0];
    e_perr = |(h & 7'h18) && !m_rep[1];
    e_merr = (|(h & 7'h41) && !m_rep[2]) ? (NMST'(1) << id) : '0;
    m_stat = (m_stat & ~((wr && a == 2'd0) ? wd[6:0] : 7'h0)) | h;
    if (wr && a == 2'd1) m_det = wd[6:0];
    if (wr && a == 2'd2) m_rep = wd[2:0];
    @(posedge clk); #1;
    check("R5 serr_o", DW'(serr_o), DW'(e_serr));
    check("R6 perr_o", DW'(perr_o), DW'(e_perr));
    check("R7 merr_o", DW'(merr_o), DW'(e_merr));
    check(rtag, reg_rdata, model_read(a));
  endtask

  initial begin
    int seed;
    seed = 32'h1F2E3D4C;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    #1;
    check("R1 serr_o", DW'(serr_o), '0);
    check("R1 perr_o", DW'(perr_o), '0);
    check("R1 merr_o", DW'(merr_o), '0);
    for (int a = 0; a < 4; a++) begin
      reg_addr = 2'(a); #1;
      check("R1 rdata", reg_rdata, '0);
    end
    @(negedge clk); rst_n = 1;

    // R2: each source alone, status sticky
    for (int s = 0; s < 7; s++) step(7'(1 << s), 4'(s + 3), 0, 2'd0, '0, "R2 status");
    step('0, '0, 0, 2'd0, '0, "R2 sticky");
    // R4: clear odd bits while source 1 fires again
    step(7'h02, '0, 1, 2'd0, 16'hFFAA, "R4 clear with set");
    step('0, '0, 1, 2'd0, 16'h0000, "R4 zero write");
    step('0, '0, 1, 2'd0, 16'h007F, "R4 clear all");
    // R3: detection masked sources
    step('0, '0, 1, 2'd1, 16'h0049, "R9 det mask");
    step(7'h7F, 4'd9, 0, 2'd0, '0, "R3 masked status");
    step('0, '0, 1, 2'd0, 16'h007F, "R4 clear all");
    step('0, '0, 1, 2'd1, 16'h0000, "R9 det mask");
    // R8: reporting masks silence lines, status still captured
    step('0, '0, 1, 2'd2, 16'hFFFF, "R9 rep mask");
    step(7'h7F, 4'd15, 0, 2'd0, '0, "R8 status kept");
    check("R8 serr silent", DW'(serr_o), '0);
    check("R8 merr silent", DW'(merr_o), '0);
    step('0, '0, 1, 2'd2, 16'h0000, "R9 rep mask");
    step('0, '0, 0, 2'd3, '0, "R9 unused addr");
    step(7'h40, 4'd0, 0, 2'd0, '0, "R7 master 0");

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      logic [1:0] a;
      r = $urandom;
      a = r[9:8];
      step(r[6:0] & {7{r[7]}}, r[13:10], (r[17:16] == 2'b00), a,
           (a == 2'd1) ? (r[31:18] & 16'h0055) : DW'(r[31:18]),
           (a == 2'd0) ? "R2 status" : "R9 rdata");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        errors++;
        $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
      end
    end
  end
endmodule